// File: doc/BRIEF.md
# Virtual-Tag Store Forwarding Checker

This block serves loads that may take their data from stores still held in a store queue. Each queue slot holds a virtual tag, a physical tag, a byte-enable mask and the store data. A load presents both of its tags, a byte mask and its queue position. Only stores older than the load are searched. The virtual-tag compare alone decides which bytes are forwarded. Each byte comes from the youngest older store that writes it. This lets forwarding start before the physical address has been translated.

The same search is run in parallel on the physical tags. If the virtual and physical hit vectors differ, the forwarded data may be wrong, for example when two virtual addresses map to one physical line. In that case a registered fail pulse is raised one cycle after the lookup. The pulse asks the surrounding logic to flush the store queue and to drain the committed store buffer. The pulse also clears every slot held by this block.

Queue positions are written `{wrap, index}`, with the index in the low bits and the wrap bit on top. A slot is older than the load when it lies in the circular window that starts at the head pointer and ends just before the load pointer. When the wrap bits differ and the indexes are equal, the window covers the whole queue.

Top module: `sfc_top`

## Requirements
- R1: After reset `fail_flush` is 0 and every slot is empty, so no lookup forwards any byte.
- R2: A write with `wr_en` high fills slot `wr_idx` and marks it valid on the next clock edge, unless `fail_flush` is high in that cycle.
- R3: A slot takes part in a lookup only if it lies in the circular window from `hd_ptr` up to, but not including, `ld_ptr`. This includes windows that cross the wrap point.
- R4: For every byte `b` with `ld_mask[b]` set, `fwd_mask[b]` is 1 when some valid older slot has a matching virtual tag and store-mask bit `b` set. Byte `b` of `fwd_data` (bits `8b+7:8b`) then comes from the youngest such slot, the one nearest below `ld_ptr`. All other bytes of `fwd_data` and `fwd_mask` are 0. The outputs are combinational in the lookup cycle.
- R5: The choice of forwarded data ignores the physical tags. A slot with a matching virtual tag and a differing physical tag still forwards its bytes.
- R6: The per-slot hit is: valid, older, tag equal and any overlap between store mask and load mask. It is computed for the virtual and the physical tags. `fail_flush` is 1 in the cycle after a valid lookup whose two hit vectors differ, and 0 otherwise.
- R7: While `ld_valid` is 0, `fwd_mask` and `fwd_data` are 0 and `fail_flush` is 0 in the next cycle, whatever the other load inputs are.
- R8: In a cycle where `fail_flush` is 1, all slots become empty at the clock edge, and a write in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store slot write strobe |
| wr_idx | input | IDX_W | Slot written |
| wr_vtag | input | VTAG_W | Store virtual tag |
| wr_ptag | input | PTAG_W | Store physical tag |
| wr_mask | input | NBYTES | Store byte enables |
| wr_data | input | 8*NBYTES | Store data |
| hd_ptr | input | IDX_W+1 | Oldest queue position `{wrap, index}` |
| ld_valid | input | 1 | Load lookup request valid |
| ld_ptr | input | IDX_W+1 | First queue position younger than the load `{wrap, index}` |
| ld_vtag | input | VTAG_W | Load virtual tag |
| ld_ptag | input | PTAG_W | Load physical tag |
| ld_mask | input | NBYTES | Load byte enables |
| fwd_mask | output | NBYTES | Bytes supplied by forwarding |
| fwd_data | output | 8*NBYTES | Forwarded bytes, 0 where not supplied |
| fail_flush | output | 1 | Registered forward-fail pulse: flush queue and drain committed buffer |

## Verification
The assertions assume that `hd_ptr` and `ld_ptr` are consistent, meaning the load pointer lies no more than one queue depth past the head pointer. They also assume that inputs are held at 0 during reset. The stimulus follows both rules. It draws a head pointer and a window size from 0 to the depth, adds them to get the load pointer, and keeps the load strobe low during reset. Tags are drawn from a tiny range so that hits and overlapping masks are frequent. The physical tag normally follows the virtual tag and occasionally aliases, which makes mismatches, and therefore flushes, rare but regular.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    // Circular-window age test: slot lies in [head, load) of the queue.
    function automatic logic slot_older(input int unsigned slot,
                                        input int unsigned hd_idx,
                                        input logic        hd_wrap,
                                        input int unsigned ld_idx,
                                        input logic        ld_wrap);
        if (hd_wrap == ld_wrap)
            return (slot >= hd_idx) && (slot < ld_idx);
        else
            return (slot >= hd_idx) || (slot < ld_idx);
    endfunction

    // Non-zero overlap between two byte-enable masks.
    function automatic logic masks_touch(input logic [63:0] a, input logic [63:0] b);
        return |(a & b);
    endfunction

endpackage

// File: rtl/sfc_store_array.sv
module sfc_store_array #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int VTAG_W = 12,
    parameter int PTAG_W = 16,
    parameter int NBYTES = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              flush,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [VTAG_W-1:0]                 wr_vtag,
    input  logic [PTAG_W-1:0]                 wr_ptag,
    input  logic [NBYTES-1:0]                 wr_mask,
    input  logic [8*NBYTES-1:0]               wr_data,
    output logic [DEPTH-1:0]                  ent_valid,
    output logic [DEPTH-1:0][VTAG_W-1:0]      ent_vtag,
    output logic [DEPTH-1:0][PTAG_W-1:0]      ent_ptag,
    output logic [DEPTH-1:0][NBYTES-1:0]      ent_mask,
    output logic [DEPTH-1:0][8*NBYTES-1:0]    ent_data
);
    localparam int DATA_W = 8 * NBYTES;

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic              v_q;
        logic [VTAG_W-1:0] vt_q;
        logic [PTAG_W-1:0] pt_q;
        logic [NBYTES-1:0] mk_q;
        logic [DATA_W-1:0] dt_q;
        logic              hit_wr;

        assign hit_wr = wr_en && (wr_idx == IDX_W'(s));

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                v_q <= 1'b0;
            end else if (hit_wr) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!flush && hit_wr) begin
                vt_q <= wr_vtag;
                pt_q <= wr_ptag;
                mk_q <= wr_mask;
                dt_q <= wr_data;
            end
        end

        assign ent_valid[s] = v_q;
        assign ent_vtag[s]  = vt_q;
        assign ent_ptag[s]  = pt_q;
        assign ent_mask[s]  = mk_q;
        assign ent_data[s]  = dt_q;
    end

    // R8: a flush cycle leaves every slot empty afterwards
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
        $past(flush) |-> (ent_valid == '0));

    // R2: a write outside a flush cycle leaves its slot valid
    p_write_fills_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> ent_valid[$past(wr_idx)]);

endmodule

// File: rtl/sfc_tag_match.sv
module sfc_tag_match #(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 12,
    parameter int NBYTES = 8
) (
    input  logic                         ld_valid,
    input  logic [TAG_W-1:0]             ld_tag,
    input  logic [NBYTES-1:0]            ld_mask,
    input  logic [DEPTH-1:0]             ent_valid,
    input  logic [DEPTH-1:0]             ent_older,
    input  logic [DEPTH-1:0][TAG_W-1:0]  ent_tag,
    input  logic [DEPTH-1:0][NBYTES-1:0] ent_mask,
    output logic [DEPTH-1:0]             hit
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        logic tag_eq;
        logic overlap;
        assign tag_eq  = (ent_tag[s] == ld_tag);
        assign overlap = sfc_pkg::masks_touch(64'(ent_mask[s]), 64'(ld_mask));
        assign hit[s]  = ld_valid && ent_valid[s] && ent_older[s] && tag_eq && overlap;
    end
endmodule

// File: rtl/sfc_byte_merge.sv
module sfc_byte_merge #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int NBYTES = 8
) (
    input  logic [DEPTH-1:0]                vhit,
    input  logic [DEPTH-1:0][NBYTES-1:0]    ent_mask,
    input  logic [DEPTH-1:0][8*NBYTES-1:0]  ent_data,
    input  logic [IDX_W-1:0]                ld_idx,
    input  logic [NBYTES-1:0]               ld_mask,
    output logic [NBYTES-1:0]               fwd_mask,
    output logic [8*NBYTES-1:0]             fwd_data
);
    // Walk from the oldest candidate to the youngest; later writes win,
    // so the slot just below the load pointer has the final say per byte.
    always_comb begin
        fwd_mask = '0;
        fwd_data = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            logic [IDX_W-1:0] slot;
            slot = ld_idx - IDX_W'(k + 1);
            for (int b = 0; b < NBYTES; b++) begin
                if (vhit[slot] && ent_mask[slot][b] && ld_mask[b]) begin
                    fwd_mask[b]        = 1'b1;
                    fwd_data[8*b +: 8] = ent_data[slot][8*b +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/sfc_top.sv
module sfc_top #(
    parameter int DEPTH  = 8,
    parameter int IDX_W  = 3,
    parameter int VTAG_W = 12,
    parameter int PTAG_W = 16,
    parameter int NBYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [VTAG_W-1:0]    wr_vtag,
    input  logic [PTAG_W-1:0]    wr_ptag,
    input  logic [NBYTES-1:0]    wr_mask,
    input  logic [8*NBYTES-1:0]  wr_data,
    input  logic [IDX_W:0]       hd_ptr,
    input  logic                 ld_valid,
    input  logic [IDX_W:0]       ld_ptr,
    input  logic [VTAG_W-1:0]    ld_vtag,
    input  logic [PTAG_W-1:0]    ld_ptag,
    input  logic [NBYTES-1:0]    ld_mask,
    output logic [NBYTES-1:0]    fwd_mask,
    output logic [8*NBYTES-1:0]  fwd_data,
    output logic                 fail_flush
);
    localparam int DATA_W = 8 * NBYTES;

    typedef struct packed {
        logic             wrap;
        logic [IDX_W-1:0] idx;
    } qpos_t;

    qpos_t hd_pos, ld_pos;
    assign hd_pos = qpos_t'(hd_ptr);
    assign ld_pos = qpos_t'(ld_ptr);

    logic [DEPTH-1:0]              ent_valid;
    logic [DEPTH-1:0][VTAG_W-1:0]  ent_vtag;
    logic [DEPTH-1:0][PTAG_W-1:0]  ent_ptag;
    logic [DEPTH-1:0][NBYTES-1:0]  ent_mask;
    logic [DEPTH-1:0][DATA_W-1:0]  ent_data;
    logic [DEPTH-1:0]              ent_older;
    logic [DEPTH-1:0]              vhit, phit;

    sfc_store_array #(
        .DEPTH(DEPTH), .IDX_W(IDX_W), .VTAG_W(VTAG_W), .PTAG_W(PTAG_W), .NBYTES(NBYTES)
    ) u_array (
        .clk(clk), .rst(rst), .flush(fail_flush),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vtag(wr_vtag), .wr_ptag(wr_ptag),
        .wr_mask(wr_mask), .wr_data(wr_data),
        .ent_valid(ent_valid), .ent_vtag(ent_vtag), .ent_ptag(ent_ptag),
        .ent_mask(ent_mask), .ent_data(ent_data)
    );

    for (genvar s = 0; s < DEPTH; s++) begin : g_age
        assign ent_older[s] = sfc_pkg::slot_older(32'(s), 32'(hd_pos.idx), hd_pos.wrap,
                                                  32'(ld_pos.idx), ld_pos.wrap);
    end

    sfc_tag_match #(.DEPTH(DEPTH), .TAG_W(VTAG_W), .NBYTES(NBYTES)) u_vmatch (
        .ld_valid(ld_valid), .ld_tag(ld_vtag), .ld_mask(ld_mask),
        .ent_valid(ent_valid), .ent_older(ent_older), .ent_tag(ent_vtag),
        .ent_mask(ent_mask), .hit(vhit)
    );

    sfc_tag_match #(.DEPTH(DEPTH), .TAG_W(PTAG_W), .NBYTES(NBYTES)) u_pmatch (
        .ld_valid(ld_valid), .ld_tag(ld_ptag), .ld_mask(ld_mask),
        .ent_valid(ent_valid), .ent_older(ent_older), .ent_tag(ent_ptag),
        .ent_mask(ent_mask), .hit(phit)
    );

    sfc_byte_merge #(.DEPTH(DEPTH), .IDX_W(IDX_W), .NBYTES(NBYTES)) u_merge (
        .vhit(vhit), .ent_mask(ent_mask), .ent_data(ent_data),
        .ld_idx(ld_pos.idx), .ld_mask(ld_mask),
        .fwd_mask(fwd_mask), .fwd_data(fwd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) fail_flush <= 1'b0;
        else     fail_flush <= (vhit != phit);
    end

    // R1: coming out of reset nothing is held and no flush is pending
    p_clean_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ent_valid == '0) && !fail_flush);

    // R7: an idle load port forwards nothing
    p_idle_no_fwd_r7: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> (fwd_mask == '0) && (fwd_data == '0));

    // R6: a fail pulse always follows a valid lookup
    p_fail_after_lookup_r6: assert property (@(posedge clk) disable iff (rst)
        fail_flush |-> $past(ld_valid));

    // R6: agreeing hit vectors never raise a fail
    p_agree_no_fail_r6: assert property (@(posedge clk) disable iff (rst)
        (vhit == phit) |=> !fail_flush);

    // R5: forwarded bytes exist only when a virtual hit exists
    p_fwd_from_vhit_r5: assert property (@(posedge clk) disable iff (rst)
        (fwd_mask != '0) |-> (vhit != '0));

    // R4: forwarding stays inside the load's bytes
    p_fwd_in_load_r4: assert property (@(posedge clk) disable iff (rst)
        (fwd_mask & ~ld_mask) == '0);

endmodule

// File: tb/sfc_top_tb.sv
`timescale 1ns/1ps
module sfc_top_tb;
    localparam int DEPTH  = 8;
    localparam int IDX_W  = 3;
    localparam int VTAG_W = 12;
    localparam int PTAG_W = 16;
    localparam int NBYTES = 8;
    localparam int DATA_W = 8 * NBYTES;
    localparam real CLK_NS = 8.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [VTAG_W-1:0] wr_vtag = '0;
    logic [PTAG_W-1:0] wr_ptag = '0;
    logic [NBYTES-1:0] wr_mask = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [IDX_W:0]    hd_ptr = '0;
    logic              ld_valid = 1'b0;
    logic [IDX_W:0]    ld_ptr = '0;
    logic [VTAG_W-1:0] ld_vtag = '0;
    logic [PTAG_W-1:0] ld_ptag = '0;
    logic [NBYTES-1:0] ld_mask = '0;
    logic [NBYTES-1:0] fwd_mask;
    logic [DATA_W-1:0] fwd_data;
    logic              fail_flush;

    always #(CLK_NS/2) clk = ~clk;

    sfc_top #(.DEPTH(DEPTH), .IDX_W(IDX_W), .VTAG_W(VTAG_W), .PTAG_W(PTAG_W),
              .NBYTES(NBYTES)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vtag(wr_vtag),
        .wr_ptag(wr_ptag), .wr_mask(wr_mask), .wr_data(wr_data), .hd_ptr(hd_ptr),
        .ld_valid(ld_valid), .ld_ptr(ld_ptr), .ld_vtag(ld_vtag), .ld_ptag(ld_ptag),
        .ld_mask(ld_mask), .fwd_mask(fwd_mask), .fwd_data(fwd_data),
        .fail_flush(fail_flush)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference state
    bit                m_valid [DEPTH];
    logic [VTAG_W-1:0] m_vt [DEPTH];
    logic [PTAG_W-1:0] m_pt [DEPTH];
    logic [NBYTES-1:0] m_mk [DEPTH];
    logic [DATA_W-1:0] m_dt [DEPTH];
    bit                exp_fail = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
        end
    endtask

    // distance below the load pointer, 1..DEPTH
    function automatic int dist_of(input int slot);
        return ((int'(ld_ptr[IDX_W-1:0]) - slot - 1 + DEPTH) % DEPTH) + 1;
    endfunction

    function automatic int window_size();
        return (int'(ld_ptr) - int'(hd_ptr) + 2*DEPTH) % (2*DEPTH);
    endfunction

    // Check combinational outputs and the pending fail, then advance one clock.
    task automatic tick(input string req);
        bit [DEPTH-1:0] vv, pv;
        logic [NBYTES-1:0] em;
        logic [DATA_W-1:0] ed;
        #1;
        vv = '0; pv = '0; em = '0; ed = '0;
        for (int i = 0; i < DEPTH; i++) begin
            bit old, ov;
            old = dist_of(i) <= window_size();
            ov  = (m_mk[i] & ld_mask) != '0;
            vv[i] = ld_valid && m_valid[i] && old && ov && (m_vt[i] == ld_vtag);
            pv[i] = ld_valid && m_valid[i] && old && ov && (m_pt[i] == ld_ptag);
        end
        for (int b = 0; b < NBYTES; b++) begin
            int best;
            best = DEPTH + 1;
            for (int i = 0; i < DEPTH; i++) begin
                if (vv[i] && m_mk[i][b] && ld_mask[b] && dist_of(i) < best) begin
                    best = dist_of(i);
                    em[b] = 1'b1;
                    ed[8*b +: 8] = m_dt[i][8*b +: 8];
                end
            end
        end
        chk(fwd_mask === em, {req, " fwd_mask"}, 64'(fwd_mask), 64'(em));
        chk(fwd_data === ed, {req, " fwd_data"}, fwd_data, ed);
        chk(fail_flush === exp_fail, "R6 fail_flush", 64'(fail_flush), 64'(exp_fail));
        if (exp_fail) begin
            for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
        end else if (wr_en) begin
            m_valid[wr_idx] = 1'b1;
            m_vt[wr_idx] = wr_vtag;
            m_pt[wr_idx] = wr_ptag;
            m_mk[wr_idx] = wr_mask;
            m_dt[wr_idx] = wr_data;
        end
        exp_fail = (vv != pv);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input int idx, input int vt, input int pt,
                       input logic [NBYTES-1:0] mk, input logic [DATA_W-1:0] dt);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_vtag = VTAG_W'(vt);
        wr_ptag = PTAG_W'(pt); wr_mask = mk; wr_data = dt;
    endtask

    task automatic look(input bit v, input int hd, input int ld, input int vt,
                        input int pt, input logic [NBYTES-1:0] mk);
        ld_valid = v; hd_ptr = (IDX_W+1)'(hd); ld_ptr = (IDX_W+1)'(ld);
        ld_vtag = VTAG_W'(vt); ld_ptag = PTAG_W'(pt); ld_mask = mk;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 1'b0; m_vt[i] = '0; m_pt[i] = '0; m_mk[i] = '0; m_dt[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 chk(fail_flush === 1'b0, "R1 reset fail_flush", 64'(fail_flush), 64'd0);
        // R1: full window, everything enabled: nothing held yet
        look(1, 0, DEPTH + 0 + DEPTH, 5, 5, '1);
        look(1, 0, DEPTH, 5, 5, '1);
        #1 chk(fwd_mask === '0, "R1 empty after reset", 64'(fwd_mask), 64'd0);
        tick("R1");
        look(0, 0, 0, 0, 0, '0);

        // R2/R4: two overlapping stores, plus a third outside the later window
        put(0, 5, 5, 8'h0F, {8{8'h11}}); tick("R2");
        put(1, 5, 5, 8'h3C, {8{8'h22}}); tick("R2");
        put(2, 5, 5, 8'hFF, {8{8'h44}}); tick("R2");
        wr_en = 1'b0;
        look(1, 0, 2, 5, 5, 8'hFF);
        #1 chk(fwd_mask === 8'h3F, "R4 youngest per byte mask", 64'(fwd_mask), 64'h3F);
        chk(fwd_data === 64'h0000_2222_2222_1111, "R4 youngest per byte data",
            fwd_data, 64'h0000_2222_2222_1111);
        tick("R4");
        // R3: window 6,7,0 across the wrap point (head {0,6}, load {1,1})
        look(1, 6, DEPTH + 1, 5, 5, 8'hFF);
        #1 chk(fwd_mask === 8'h0F, "R3 wrap window", 64'(fwd_mask), 64'h0F);
        tick("R3");
        // R7: idle load port with hitting tags
        look(0, 0, 3, 5, 5, 8'hFF);
        #1 chk(fwd_mask === '0, "R7 idle port", 64'(fwd_mask), 64'd0);
        tick("R7");
        #1 chk(fail_flush === 1'b0, "R7 no fail after idle", 64'(fail_flush), 64'd0);
        // R5/R6: aliasing store, virtual tag matches, physical tag differs
        put(3, 5, 9, 8'hC0, {8{8'h33}}); tick("R2");
        wr_en = 1'b0;
        look(1, 0, 4, 5, 5, 8'hFF);
        #1 chk(fwd_data[63:48] === 16'h3333, "R5 virtual match selects",
               64'(fwd_data[63:48]), 64'h3333);
        tick("R5");
        // R8: the flush cycle drops a write
        look(0, 0, 0, 0, 0, '0);
        put(4, 5, 5, 8'hFF, {8{8'h55}});
        #1 chk(fail_flush === 1'b1, "R6 fail after mismatch", 64'(fail_flush), 64'd1);
        tick("R8");
        wr_en = 1'b0;
        look(1, 0, DEPTH, 5, 5, 8'hFF);
        #1 chk(fwd_mask === '0, "R8 emptied by flush", 64'(fwd_mask), 64'd0);
        tick("R8");

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int hd, sz;
            wr_en = 1'b0;
            if ($urandom_range(1, 0) == 1) begin
                int vt;
                vt = int'($urandom_range(3, 0));
                put(int'($urandom_range(DEPTH - 1, 0)), vt,
                    ($urandom_range(15, 0) == 0) ? int'($urandom_range(3, 0)) + 16 : vt,
                    NBYTES'($urandom), {$urandom, $urandom});
            end
            hd = int'($urandom_range(2*DEPTH - 1, 0));
            sz = int'($urandom_range(DEPTH, 0));
            begin
                int vt;
                vt = int'($urandom_range(3, 0));
                look($urandom_range(3, 0) != 0, hd, (hd + sz) % (2*DEPTH), vt,
                     ($urandom_range(31, 0) == 0) ? vt + 16 : vt, NBYTES'($urandom));
            end
            tick("R4");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule